// File: doc/BRIEF.md
# Masked Vector Load Unit

This block fills a 256-bit vector destination from a byte-addressed memory port. Each load is controlled by a per-lane mask. The lane width is chosen for each operation: 8, 16, 32 or 64 bits. Where a mask bit is clear, the lane either keeps the matching lane of a source operand (merge) or is cleared (zero). A full-load flag ignores the mask and fills every lane from memory.

Two variants are supported. The strict-alignment variant checks that the base address sits on a 32-byte boundary. If it does not, the block reports a protection fault, makes no memory access and leaves the destination unchanged. The relaxed variant accepts any byte address. Memory is read in aligned 32-byte beats: one beat when the address is aligned, two when it is not. A byte rotator then lines up the two beats into the vector.

Each operation begins with a valid/ready handshake. It ends with a one-cycle done pulse, which arrives together with the result and the fault flag.

Top module: `masked_vec_load`

## Requirements
- R1: `req_ready` is high only when the unit is idle, and an operation is accepted on a clock edge where `req_valid` and `req_ready` are both high. Each accepted operation produces exactly one `done` pulse, one cycle long.
- R2: `req_width` selects the lane size. The codes 0, 1, 2 and 3 give 8, 16, 32 and 64 bits, which is 32, 16, 8 and 4 lanes. Lane j is controlled by `req_mask[j]`, and mask bits at or above the lane count have no effect.
- R3: An active lane j of width W bytes receives the memory bytes at addresses base+j*W through base+j*W+W-1, with the lowest address in the lowest byte of the lane.
- R4: With `req_zero`=0 (merge), a lane whose mask bit is clear takes the same lane of `req_src`.
- R5: With `req_zero`=1 (zero), a lane whose mask bit is clear is written with zero.
- R6: When `req_aligned`=1 and `req_addr[4:0]` is nonzero, `fault` is raised together with `done`. No memory request is issued, and `dst` keeps its previous value.
- R7: When `req_aligned`=0, no fault is raised for any address. An address with `req_addr[4:0]`=0 issues one memory request. Any other address issues two requests, at the 32-byte line holding the base address and at the next line. Every request address is 32-byte aligned.
- R8: When `req_full`=1, every lane is loaded from memory regardless of `req_mask`.
- R9: Bits of `dst` above bit 255 always read zero.
- R10: After reset: `req_ready`=1, `done`=0, `fault`=0, `mem_req_valid`=0, and `dst`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_addr | input | ADDR_W | Byte base address |
| req_width | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64 bits) |
| req_zero | input | 1 | 1 = zero inactive lanes, 0 = merge from source |
| req_aligned | input | 1 | 1 = strict 32-byte alignment check |
| req_full | input | 1 | 1 = ignore mask, load all lanes |
| req_mask | input | 32 | Per-lane enable |
| req_src | input | 256 | Merge source vector |
| mem_req_valid | output | 1 | Memory beat request |
| mem_req_addr | output | ADDR_W | 32-byte-aligned beat address |
| mem_rsp_valid | input | 1 | Memory beat response |
| mem_rsp_data | input | 256 | Beat data, lowest address in byte 0 |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Protection fault, valid with done |
| dst | output | DEST_W | Destination vector |

## Verification
If the stored beat offset were wrong, every active byte would appear rotated at `dst` on the next `done` pulse. If the lane-to-mask mapping were wrong, lanes whose mask bit is clear would pick up memory bytes instead of source or zero bytes, and this also shows on the next `done`. A beat counter that is wrong shows up before `done`, as a count of memory requests that differs from one or two per operation. A faulted request that still updated state would appear as a changed `dst`, or as a memory request, during the same short operation.

// File: rtl/masked_vec_load.sv
module masked_vec_load #(
  parameter int ADDR_W = 32,
  parameter int DEST_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_width,
  input  logic              req_zero,
  input  logic              req_aligned,
  input  logic              req_full,
  input  logic [31:0]       req_mask,
  input  logic [255:0]      req_src,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [255:0]      mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [DEST_W-1:0] dst
);
  localparam int VEC_W  = 256;
  localparam int VEC_B  = VEC_W / 8;
  localparam int OFF_W  = $clog2(VEC_B);
  localparam int LINE_W = ADDR_W - OFF_W;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_ASM, S_DONE} state_t;
  state_t state;

  logic [ADDR_W-1:0] op_addr;
  logic [1:0]        op_w;
  logic              op_zero, op_align, op_full, fault_q, beat_q;
  logic [31:0]       op_mask;
  logic [VEC_W-1:0]  op_src, lo_q, hi_q, dst_q, assembled;
  logic [OFF_W-1:0]  off;

  assign off          = op_addr[OFF_W-1:0];
  assign req_ready    = (state == S_IDLE);
  assign mem_req_valid = (state == S_REQ);
  assign mem_req_addr = {op_addr[ADDR_W-1:OFF_W] + LINE_W'(beat_q), {OFF_W{1'b0}}};
  assign done         = (state == S_DONE);
  assign fault        = done & fault_q;
  assign dst          = {{(DEST_W-VEC_W){1'b0}}, dst_q};

  logic [2*VEC_W-1:0] rotated;
  assign rotated = {hi_q, lo_q} >> {off, 3'b000};

  for (genvar b = 0; b < VEC_B; b++) begin : g_byte
    logic [4:0] lane;
    logic       act;
    assign lane = 5'(b) >> op_w;
    assign act  = op_full | op_mask[lane];
    assign assembled[8*b +: 8] = act ? rotated[8*b +: 8]
                                     : (op_zero ? 8'h00 : op_src[8*b +: 8]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_addr  <= '0;
      op_w     <= '0;
      op_zero  <= 1'b0;
      op_align <= 1'b0;
      op_full  <= 1'b0;
      op_mask  <= '0;
      op_src   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      dst_q    <= '0;
      fault_q  <= 1'b0;
      beat_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_addr  <= req_addr;
          op_w     <= req_width;
          op_zero  <= req_zero;
          op_align <= req_aligned;
          op_full  <= req_full;
          op_mask  <= req_mask;
          op_src   <= req_src;
          beat_q   <= 1'b0;
          if (req_aligned && req_addr[OFF_W-1:0] != '0) begin
            fault_q <= 1'b1;
            state   <= S_DONE;
          end else begin
            fault_q <= 1'b0;
            state   <= S_REQ;
          end
        end
        S_REQ: state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!beat_q) lo_q <= mem_rsp_data;
          else         hi_q <= mem_rsp_data;
          if (!beat_q && off != '0) begin
            beat_q <= 1'b1;
            state  <= S_REQ;
          end else begin
            state <= S_ASM;
          end
        end
        S_ASM: begin
          dst_q <= assembled;
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  assert_zero_empty_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && op_zero && !op_full && op_mask == 32'h0 |-> dst_q == '0);
  assert_fault_keeps_dst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $stable(dst_q));
  assert_relaxed_no_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !op_align |-> !fault);
  assert_second_beat_only_unaligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && beat_q |-> off != '0);
endmodule

// File: tb/masked_vec_load_test.sv
`timescale 1ns/1ps
module masked_vec_load_test;
  localparam int ADDR_W = 32;
  localparam int DEST_W = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_zero = 1'b0, req_aligned = 1'b0, req_full = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_width = '0;
  logic [31:0] req_mask = '0;
  logic [255:0] req_src = '0;
  logic req_ready, mem_req_valid, done, fault;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [255:0] mem_rsp_data;
  logic [DEST_W-1:0] dst;

  always #2.5 clk = ~clk;

  masked_vec_load #(.ADDR_W(ADDR_W), .DEST_W(DEST_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_width(req_width), .req_zero(req_zero),
    .req_aligned(req_aligned), .req_full(req_full), .req_mask(req_mask),
    .req_src(req_src), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .dst(dst));

  function automatic logic [7:0] mb(input logic [31:0] a);
    return 8'(a * 13 + (a >> 8) + 7);
  endfunction

  function automatic logic [255:0] line_of(input logic [31:0] a);
    logic [255:0] r;
    for (int b = 0; b < 32; b++) r[8*b +: 8] = mb(a + 32'(b));
    return r;
  endfunction

  // memory model: fixed two-cycle response latency
  logic p1_v, p2_v;
  logic [31:0] p1_a, p2_a;
  always @(posedge clk) begin
    if (!rst_n) begin
      p1_v <= 1'b0; p2_v <= 1'b0; mem_rsp_valid <= 1'b0;
      p1_a <= '0; p2_a <= '0; mem_rsp_data <= '0;
    end else begin
      p1_v <= mem_req_valid; p1_a <= mem_req_addr;
      p2_v <= p1_v; p2_a <= p1_a;
      mem_rsp_valid <= p2_v;
      mem_rsp_data  <= line_of(p2_a);
    end
  end

  int checks = 0, errors = 0;
  logic [255:0] q_dst[$];
  logic q_fault[$];
  int q_req[$];
  string q_tag[$];
  logic [255:0] model_dst = '0;
  int req_seen = 0;

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid) req_seen++;
      if (done) begin
        if (q_dst.size() == 0) begin
          check(1'b0, "R1 unexpected done", 256'(done), 256'(0));
        end else begin
          logic [255:0] ed; logic ef; int er; string t;
          ed = q_dst.pop_front(); ef = q_fault.pop_front();
          er = q_req.pop_front(); t = q_tag.pop_front();
          check(dst[255:0] == ed, {t, " dst"}, dst[255:0], ed);
          check(fault == ef, {t, " R6/R7 fault"}, 256'(fault), 256'(ef));
          check(req_seen == er, {t, " R7 request count"}, 256'(req_seen), 256'(er));
          check(dst[DEST_W-1:256] == '0, "R9 upper bits", dst[DEST_W-1:256], 256'(0));
        end
        req_seen = 0;
      end
    end
  end

  task automatic do_op(input string tag, input logic [1:0] w, input logic z,
                       input logic al, input logic fu, input logic [31:0] m,
                       input logic [255:0] s, input logic [31:0] a);
    logic [255:0] e; logic f; int nr;
    f = al && (a[4:0] != 5'd0);
    if (f) begin
      e = model_dst; nr = 0;
    end else begin
      for (int b = 0; b < 32; b++) begin
        int ln;
        ln = b >> w;
        e[8*b +: 8] = (fu || m[ln]) ? mb(a + 32'(b)) : (z ? 8'h00 : s[8*b +: 8]);
      end
      model_dst = e;
      nr = (a[4:0] == 5'd0) ? 1 : 2;
    end
    q_dst.push_back(e); q_fault.push_back(f); q_req.push_back(nr); q_tag.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_width = w; req_zero = z; req_aligned = al;
    req_full = fu; req_mask = m; req_src = s; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1 busy after accept", 256'(req_ready), 256'(0));
    while (q_dst.size() != 0) @(negedge clk);
  endtask

  logic [255:0] srcA;

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 32; b++) srcA[8*b +: 8] = 8'hC0 + 8'(b);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(req_ready == 1'b1, "R10 req_ready", 256'(req_ready), 256'(1));
    check(done == 1'b0, "R10 done", 256'(done), 256'(0));
    check(fault == 1'b0, "R10 fault", 256'(fault), 256'(0));
    check(mem_req_valid == 1'b0, "R10 mem_req_valid", 256'(mem_req_valid), 256'(0));
    check(dst == '0, "R10 dst", dst[255:0], 256'(0));
    rst_n = 1'b1;
    // R3 R4: bytes, merge, strict variant on aligned address
    do_op("R3 R4 w8 merge", 2'd0, 1'b0, 1'b1, 1'b0, 32'hA5A5_0F0F, srcA, 32'h0000_0100);
    // R2 R5: halfwords, zero mode, upper mask bits set but ignored, unaligned
    do_op("R2 R5 w16 zero", 2'd1, 1'b1, 1'b0, 1'b0, 32'hFFFF_00F3, srcA, 32'h0000_0203);
    // R6: strict variant, misaligned -> fault, dst kept
    do_op("R6 fault", 2'd2, 1'b0, 1'b1, 1'b0, 32'h0000_00FF, srcA, 32'h0000_0310);
    // R2 R7: words, merge, upper bits ignored, offset 1
    do_op("R2 R7 w32 merge", 2'd2, 1'b0, 1'b0, 1'b0, 32'hFFFF_FF5A, srcA, 32'h0000_0401);
    // R3 R5: doublewords, zero mode, offset 31
    do_op("R3 R5 w64 zero", 2'd3, 1'b1, 1'b0, 1'b0, 32'h0000_000A, srcA, 32'h0000_041F);
    // R8: full load ignores empty mask
    do_op("R8 full", 2'd0, 1'b0, 1'b0, 1'b1, 32'h0, srcA, 32'h0000_0555);
    // R5: empty mask in zero mode clears the vector
    do_op("R5 empty zero", 2'd1, 1'b1, 1'b0, 1'b0, 32'h0, srcA, 32'h0000_0600);
    // R6: fault after a zeroed dst still keeps it
    do_op("R6 fault keep", 2'd3, 1'b1, 1'b1, 1'b1, 32'hF, srcA, 32'h0000_0708);
    // R4 R7: strict variant aligned, doublewords merge
    do_op("R4 R7 w64 merge", 2'd3, 1'b0, 1'b1, 1'b0, 32'h0000_0005, srcA, 32'h0000_1000);
    // R4: empty mask merge returns source
    do_op("R4 empty merge", 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, srcA, 32'h0000_1011);
    repeat (5) @(negedge clk);
    check(done == 1'b0, "R1 no extra done", 256'(done), 256'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule